// File: doc/BRIEF.md
# Calendar and Binary Real-Time Counter

This block keeps the time of day for a chip. A one-second tick, made elsewhere, advances it. A control bit picks one of two counting modes. In calendar mode the block keeps seconds, minutes, hours, a day-of-week index, day of month, month and a two-digit year for 2000 to 2099, all as packed BCD. It works out month lengths and February 29 by itself. In binary mode it keeps a 32-bit count of elapsed seconds that wraps at the top. The counter of the mode that is not selected holds its value.

Software reaches the block through a small byte-wide register port. Reads are combinational from the address. A write to a time register takes effect only while the halt bit is set. An update flag is raised on every tick that changes the counters, so software can tell when a multi-byte read may have straddled an update. Software clears that flag by writing the control register.

Top module: `timekeep_top`

## Requirements
- R1: After synchronous reset the block is halted and in calendar mode. The time reads 2000-01-01 00:00:00 with weekday 0, the binary count is 0 and the update flag is 0. The control register at address 0 reads 0x01.
- R2: Control bit 1 selects the mode: 0 for calendar, 1 for binary. A counted tick advances only the selected counter, and the other counter keeps its value.
- R3: Seconds (address 1) and minutes (address 2) count in BCD from 00 to 59 and wrap. Hours (address 3) count from 00 to 23. When the time passes 23:59:59 it becomes 00:00:00, the day advances, and the weekday (address 4, values 0 to 6) advances and wraps from 6 to 0.
- R4: The day (address 5, BCD from 01) wraps to 01 after the last day of its month, and the month (address 6, BCD 01 to 12) then advances. April, June, September and November have 30 days. January, March, May, July, August, October and December have 31 days.
- R5: February has 29 days when the BCD year (address 7) is divisible by 4, year 00 included. Otherwise it has 28.
- R6: After December 31 of year 99 the date becomes January 01 of year 00.
- R7: In binary mode each counted tick adds one to the 32-bit count, and 0xFFFFFFFF wraps to 0. The count is read and written as bytes at addresses 8 to 11, least significant byte first.
- R8: A write to addresses 1 to 11 changes the time only while the halt bit (control bit 0) is 1. While counting, such a write is ignored.
- R9: A tick has no effect while the block is halted. A tick in the same cycle as the write that clears the halt bit is not counted. Counting resumes at the next tick.
- R10: Every counted tick sets the update flag. The flag is output `upd_flag_o` and reads as control bit 2. Writing the control register with bit 2 set clears the flag. A counted tick in the same cycle as that clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| upd_flag_o | output | 1 | Update flag, set by counted ticks |

## Verification
A tick or a write is registered at the clock edge where its strobe is high. Its result is therefore visible on `rdata_o` and `upd_flag_o` from the falling edge that follows that rising edge. The read path adds no further delay, because it is a pure address multiplexer.

The bench drives every strobe for exactly one cycle starting at a falling edge. It moves the address at a later falling edge and samples 1 ns after that edge. Each check therefore sees the state from the edge just past. The month-end sweep covers every month of all hundred years, with expected dates computed from the month-length and divisible-by-four rules.

// File: rtl/timekeep_pkg.sv
package timekeep_pkg;

    // Register addresses
    localparam int A_CTRL = 0;
    localparam int A_SEC  = 1;
    localparam int A_MIN  = 2;
    localparam int A_HOUR = 3;
    localparam int A_WDAY = 4;
    localparam int A_DAY  = 5;
    localparam int A_MON  = 6;
    localparam int A_YEAR = 7;
    localparam int A_BIN  = 8;

    // Control bit positions
    localparam int C_HALT  = 0;
    localparam int C_MODE  = 1;
    localparam int C_FLAG  = 2;

    typedef enum logic {MODE_CAL = 1'b0, MODE_BIN = 1'b1} cnt_mode_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [2:0] wday;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   wday: 3'd0, day: 8'h01, mon: 8'h01,
                                   year: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Years 00..99 map onto 2000..2099, where divisibility by 4 is exact
    function automatic logic is_leap(input logic [7:0] yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon,
                                              input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic cal_t cal_next(input cal_t c);
        cal_t n;
        n = c;
        if (c.sec != 8'h59) begin
            n.sec = bcd_inc(c.sec);
        end else begin
            n.sec = 8'h00;
            if (c.min != 8'h59) begin
                n.min = bcd_inc(c.min);
            end else begin
                n.min = 8'h00;
                if (c.hour != 8'h23) begin
                    n.hour = bcd_inc(c.hour);
                end else begin
                    n.hour = 8'h00;
                    n.wday = (c.wday == 3'd6) ? 3'd0 : c.wday + 3'd1;
                    if (c.day < month_last(c.mon, c.year)) begin
                        n.day = bcd_inc(c.day);
                    end else begin
                        n.day = 8'h01;
                        if (c.mon != 8'h12) begin
                            n.mon = bcd_inc(c.mon);
                        end else begin
                            n.mon  = 8'h01;
                            n.year = (c.year == 8'h99) ? 8'h00 : bcd_inc(c.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/timekeep_ctrl.sv
module timekeep_ctrl
    import timekeep_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        wbits_i,
    output logic              halt_o,
    output cnt_mode_e         mode_o,
    output logic              flag_o,
    output logic              adv_o
);

    logic      halt_q;
    cnt_mode_e mode_q;
    logic      flag_q;
    logic      ctrl_wr;

    assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
    assign adv_o   = tick_i && !halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b1;
            mode_q <= MODE_CAL;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                halt_q <= wbits_i[C_HALT];
                mode_q <= cnt_mode_e'(wbits_i[C_MODE]);
            end
            if (adv_o)
                flag_q <= 1'b1;
            else if (ctrl_wr && wbits_i[C_FLAG])
                flag_q <= 1'b0;
        end
    end

    assign halt_o = halt_q;
    assign mode_o = mode_q;
    assign flag_o = flag_q;

    // R10: a counted tick always leaves the flag set
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !halt_o) |=> flag_o);

    // R10: a clear without a tick drops the flag
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_W'(A_CTRL) && wbits_i[C_FLAG] && !(tick_i && !halt_o))
        |=> !flag_o);

endmodule

// File: rtl/timekeep_cal.sv
module timekeep_cal
    import timekeep_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              wr_ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output cal_t              cal_o
);

    cal_t cal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= CAL_RESET;
        end else if (adv_i) begin
            cal_q <= cal_next(cal_q);
        end else if (wr_ok_i) begin
            case (int'(addr_i))
                A_SEC:   cal_q.sec  <= wdata_i;
                A_MIN:   cal_q.min  <= wdata_i;
                A_HOUR:  cal_q.hour <= wdata_i;
                A_WDAY:  cal_q.wday <= wdata_i[2:0];
                A_DAY:   cal_q.day  <= wdata_i;
                A_MON:   cal_q.mon  <= wdata_i;
                A_YEAR:  cal_q.year <= wdata_i;
                default: ;
            endcase
        end
    end

    assign cal_o = cal_q;

    // R3: seconds wrap from 59 to 00
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cal_o.sec == 8'h59) |=> (cal_o.sec == 8'h00));

    // R3: weekday wraps from 6 to 0 at midnight
    assert_wday_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cal_o.sec == 8'h59 && cal_o.min == 8'h59 &&
         cal_o.hour == 8'h23 && cal_o.wday == 3'd6) |=> (cal_o.wday == 3'd0));

    // R6: last second of year 99 rolls to year 00, January 01
    assert_century_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cal_o.sec == 8'h59 && cal_o.min == 8'h59 && cal_o.hour == 8'h23 &&
         cal_o.day == 8'h31 && cal_o.mon == 8'h12 && cal_o.year == 8'h99)
        |=> (cal_o.year == 8'h00 && cal_o.mon == 8'h01 && cal_o.day == 8'h01));

    // R8, R9: with neither an accepted write nor a counted tick, time holds
    assert_cal_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !wr_ok_i) |=> $stable(cal_o));

endmodule

// File: rtl/timekeep_bin.sv
module timekeep_bin
    import timekeep_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              wr_ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam int NBYTE = CNT_W / 8;

    logic [CNT_W-1:0] cnt_q;
    logic [NBYTE-1:0] byte_hit;

    for (genvar g = 0; g < NBYTE; g++) begin : g_hit
        assign byte_hit[g] = wr_ok_i && (addr_i == ADDR_W'(A_BIN + g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            for (int k = 0; k < NBYTE; k++)
                if (byte_hit[k])
                    cnt_q[k*8 +: 8] <= wdata_i;
        end
    end

    assign cnt_o = cnt_q;

    // R7: full count wraps to zero
    assert_bin_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (adv_i && cnt_o == '1) |=> (cnt_o == '0));

    // R7: each counted tick adds exactly one
    assert_bin_step_R7: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R2: binary count holds when neither counting nor written
    assert_bin_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !wr_ok_i) |=> $stable(cnt_o));

endmodule

// File: rtl/timekeep_top.sv
module timekeep_top
    import timekeep_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              upd_flag_o
);

    localparam int NBYTE = CNT_W / 8;

    logic             halt;
    cnt_mode_e        mode;
    logic             flag;
    logic             adv;
    logic             wr_ok;
    logic             cal_adv;
    logic             bin_adv;
    cal_t             cal;
    logic [CNT_W-1:0] cnt;

    timekeep_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wbits_i (wdata_i[2:0]),
        .halt_o  (halt),
        .mode_o  (mode),
        .flag_o  (flag),
        .adv_o   (adv)
    );

    assign wr_ok   = wr_en_i && halt;
    assign cal_adv = adv && (mode == MODE_CAL);
    assign bin_adv = adv && (mode == MODE_BIN);

    timekeep_cal #(.ADDR_W(ADDR_W)) u_cal (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (cal_adv),
        .wr_ok_i (wr_ok),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cal_o   (cal)
    );

    timekeep_bin #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bin (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (bin_adv),
        .wr_ok_i (wr_ok),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cnt_o   (cnt)
    );

    always_comb begin
        rdata_o = 8'h00;
        case (int'(addr_i))
            A_CTRL: rdata_o = {5'b0, flag, mode == MODE_BIN, halt};
            A_SEC:  rdata_o = cal.sec;
            A_MIN:  rdata_o = cal.min;
            A_HOUR: rdata_o = cal.hour;
            A_WDAY: rdata_o = {5'b0, cal.wday};
            A_DAY:  rdata_o = cal.day;
            A_MON:  rdata_o = cal.mon;
            A_YEAR: rdata_o = cal.year;
            default: begin
                for (int k = 0; k < NBYTE; k++)
                    if (addr_i == ADDR_W'(A_BIN + k))
                        rdata_o = cnt[k*8 +: 8];
            end
        endcase
    end

    assign upd_flag_o = flag;

    // R2: in binary mode a tick leaves the calendar untouched
    assert_cal_frozen_bin_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode == MODE_BIN && !wr_en_i) |=> $stable(cal));

    // R9: a halted block ignores ticks
    assert_halt_ignores_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && halt && !wr_en_i) |=> ($stable(cal) && $stable(cnt)));

endmodule

// File: tb/tb_timekeep_top.sv
module tb_timekeep_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       flag;

    int  errs = 0;
    int  checks = 0;
    bit  done = 1'b0;
    logic [7:0] v;
    logic [7:0] keep_sec, keep_day;

    always #2 clk = ~clk;

    timekeep_top dut (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .upd_flag_o (flag)
    );

    function automatic logic [7:0] bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int mdays(input int y, input int m);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_cal(input int y, input int mo, input int d,
                           input int h, input int mi, input int s, input int wd);
        wr(4'd0, 8'h01);
        wr(4'd1, bcd(s));
        wr(4'd2, bcd(mi));
        wr(4'd3, bcd(h));
        wr(4'd4, 8'(wd));
        wr(4'd5, bcd(d));
        wr(4'd6, bcd(mo));
        wr(4'd7, bcd(y));
        wr(4'd0, 8'h04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 8'h01);
        rd(4'd1, v); chk("R1 sec", v, 8'h00);
        rd(4'd2, v); chk("R1 min", v, 8'h00);
        rd(4'd3, v); chk("R1 hour", v, 8'h00);
        rd(4'd4, v); chk("R1 wday", v, 8'h00);
        rd(4'd5, v); chk("R1 day", v, 8'h01);
        rd(4'd6, v); chk("R1 mon", v, 8'h01);
        rd(4'd7, v); chk("R1 year", v, 8'h00);
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), v); chk("R1 bin byte", v, 8'h00);
        end
        chk("R1 flag", flag, 1'b0);

        // R9 ticks while halted are ignored
        tk();
        rd(4'd1, v); chk("R9 halted tick sec", v, 8'h00);
        chk("R9 halted tick flag", flag, 1'b0);

        // R10 flag set and clear
        wr(4'd0, 8'h00);
        tk();
        rd(4'd1, v); chk("R10 sec after tick", v, 8'h01);
        chk("R10 flag set", flag, 1'b1);
        wr(4'd0, 8'h04);
        chk("R10 flag cleared", flag, 1'b0);

        // R8 write while running ignored
        wr(4'd1, 8'h30);
        rd(4'd1, v); chk("R8 running write ignored", v, 8'h01);

        // R3 seconds/minutes sweep
        for (int i = 1; i <= 3700; i++) begin
            int t;
            t = 1 + i;
            tk();
            rd(4'd1, v); chk("R3 sec", v, bcd(t % 60));
            rd(4'd2, v); chk("R3 min", v, bcd((t / 60) % 60));
            if (i % 100 == 0) begin
                rd(4'd3, v); chk("R3 hour", v, bcd(t / 3600));
            end
        end

        // R3 midnight with weekday wrap and plain advance
        set_cal(5, 3, 14, 23, 59, 59, 6);
        tk();
        rd(4'd1, v); chk("R3 midnight sec", v, 8'h00);
        rd(4'd2, v); chk("R3 midnight min", v, 8'h00);
        rd(4'd3, v); chk("R3 midnight hour", v, 8'h00);
        rd(4'd5, v); chk("R3 midnight day", v, 8'h15);
        rd(4'd4, v); chk("R3 wday wrap", v, 8'h00);
        set_cal(5, 3, 15, 23, 59, 59, 2);
        tk();
        rd(4'd4, v); chk("R3 wday step", v, 8'h03);

        // R4 R5 R6 month-end sweep over the whole century
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int last, nm, ny;
                string tag;
                last = mdays(y, m);
                nm = (m == 12) ? 1 : m + 1;
                ny = (m == 12) ? (y + 1) % 100 : y;
                tag = (m == 2) ? "R5" : ((m == 12 && y == 99) ? "R6" : "R4");
                set_cal(y, m, last, 23, 59, 59, 0);
                tk();
                rd(4'd5, v); chk({tag, " day"}, v, 8'h01);
                rd(4'd6, v); chk({tag, " mon"}, v, bcd(nm));
                rd(4'd7, v); chk({tag, " year"}, v, bcd(ny));
                if (m == 2) begin
                    set_cal(y, 2, 28, 23, 59, 59, 0);
                    tk();
                    rd(4'd5, v); chk("R5 feb 28 next", v, (y % 4 == 0) ? 8'h29 : 8'h01);
                end
            end
        end

        // R7 and R2 binary mode
        wr(4'd0, 8'h03);
        wr(4'd8, 8'hFE); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF); wr(4'd11, 8'hFF);
        rd(4'd1, keep_sec);
        rd(4'd5, keep_day);
        wr(4'd0, 8'h06);
        tk();
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), v); chk("R7 bin all ones", v, 8'hFF);
        end
        tk();
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), v); chk("R7 bin wrap", v, 8'h00);
        end
        tk();
        rd(4'd8, v); chk("R7 bin step", v, 8'h01);
        rd(4'd1, v); chk("R2 calendar frozen sec", v, keep_sec);
        rd(4'd5, v); chk("R2 calendar frozen day", v, keep_day);
        wr(4'd0, 8'h03);
        wr(4'd8, 8'hFF); wr(4'd9, 8'h00);
        wr(4'd0, 8'h02);
        tk();
        rd(4'd8, v); chk("R7 byte carry low", v, 8'h00);
        rd(4'd9, v); chk("R7 byte carry high", v, 8'h01);
        rd(4'd0, v); chk("R2 ctrl mode bit", v & 8'h03, 8'h02);

        // R2 back to calendar: calendar moves, binary holds
        wr(4'd0, 8'h04);
        tk();
        rd(4'd1, v); chk("R2 calendar resumes", v, 8'h01);
        rd(4'd9, v); chk("R2 binary held", v, 8'h01);
        rd(4'd8, v); chk("R2 binary held low", v, 8'h00);

        // R8 halted write accepted
        wr(4'd0, 8'h01);
        wr(4'd1, 8'h42);
        rd(4'd1, v); chk("R8 halted write", v, 8'h42);

        // R9 tick with halt-clearing write is not counted
        @(negedge clk);
        addr = 4'd0; wdata = 8'h04; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(4'd1, v); chk("R9 resume tick not counted", v, 8'h42);
        tk();
        rd(4'd1, v); chk("R9 next tick counted", v, 8'h43);

        // R10 tick beats clear in the same cycle
        @(negedge clk);
        addr = 4'd0; wdata = 8'h04; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R10 set beats clear", flag, 1'b1);
        rd(4'd0, v); chk("R10 flag in ctrl", v[2], 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule